// File: doc/BRIEF.md
# Programmable Memory Address Multiplexer

This block drives the external address pins of a memory controller whose timing comes from stored pattern words. On every rising clock edge the current pattern word selects where the next address comes from. The first choice passes the internal master's address straight through. The second shifts the low pins to present a row or column address, with the shift chosen by a 3-bit mode field. The third drives the contents of a memory address register. The chosen address and its per-pin output enables are registered, so the pins change only on rising edges.

The block also holds the read-data capture stage. A read word can ask for input data to be latched half a clock early, on the falling edge; otherwise data is taken on the rising edge. In both cases the captured word reaches the master on the rising edge that follows the read word's cycle.

Addresses use descending bit numbering: `memAddr[0]` is the least significant address bit. The sixteen multiplexed pins are `memAddr[15:0]`.

Top module: `mem_addr_mux`

## Requirements
- R1: When `addrSel` is 00 (pass-through) or 11 (treated as pass-through), `memAddr` equals `masterAddr` and every `memAddrOe` bit is 1, one rising edge after the word is presented.
- R2: When `addrSel` is 01 (multiplexed) with `muxMode` 000, 001, 010 or 011, `memAddr[15:0]` equals `masterAddr` shifted right by 8, 9, 10 or 11 respectively. `memAddr[31:16]` equals `masterAddr[31:16]`, and all enables are 1.
- R3: In multiplexed mode with `muxMode` 100, the shift is 12 and pin 15 is undriven. With `muxMode` 101, the shift is 13 and pins 15 and 14 are undriven. An undriven pin outputs 0 and has its `memAddrOe` bit at 0.
- R4: In multiplexed mode, `muxMode` 110 and 111 produce the same output as 000. They also set `illegalMode`, which then stays at 1 until reset.
- R5: When `addrSel` is 10 (address register) and `sysBusMode` is 0, `memAddr` carries `marValue[17:0]` in its low 18 bits and 0 above them, with all enables 1.
- R6: When `addrSel` is 10 and `sysBusMode` is 1, the register source is refused and `memAddr` equals `masterAddr`.
- R7: When a read word (`readCycle`=1) has `utaBit`, `gpl4Dis` and `dltBit` all set, `rdData` after the second rising edge carries the `dataIn` value present at the falling edge between those two rising edges.
- R8: A read word that does not meet the R7 condition captures the `dataIn` value present at the second rising edge. This covers any of `utaBit`, `gpl4Dis` or `dltBit` at 0.
- R9: While `rstN` is low, `memAddr` is 0, `memAddrOe` is all 1, `illegalMode` is 0, `rdData` is 0 and `rdValid` is 0.
- R10: `rdValid` is 1 for exactly the cycle after a read word's capture edge. `rdData` holds its value when no read word was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pattern words change on rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| sysBusMode | input | 1 | 1 = system-bus-compatible port, address register source refused |
| addrSel | input | 2 | Address source from the pattern word: 00 pass, 01 mux, 10 register, 11 pass |
| muxMode | input | 3 | Row/column shift mode |
| masterAddr | input | 32 | Internal master's address |
| marValue | input | 32 | Memory address register contents |
| readCycle | input | 1 | Current pattern word is a read data cycle |
| utaBit | input | 1 | Transfer-acknowledge bit of the pattern word |
| gpl4Dis | input | 1 | General-purpose line 4 output disabled, shared bit acts as latch control |
| dltBit | input | 1 | Shared latch-timing bit of the pattern word |
| dataIn | input | 32 | Read data from memory |
| memAddr | output | 32 | Registered external address |
| memAddrOe | output | 32 | Per-pin output enable, 0 = pin undriven |
| illegalMode | output | 1 | Sticky flag for a reserved mux mode |
| rdData | output | 32 | Captured read data for the master |
| rdValid | output | 1 | `rdData` was updated on the last rising edge |

## Verification
The hardest case to reach is early capture. There, the only visible difference is which of two data values arrives. For it to show, `dataIn` must change inside the half cycle between the falling edge and the next rising edge. The bench holds one value across the falling edge that follows the read word. It replaces that value just after that falling edge. It then reads `rdData` after the next rising edge. The same sequence is repeated with each of the three enabling bits cleared in turn, and the bench expects the later value in those runs. The sticky illegal flag is checked by following a reserved-mode word with ordinary words.

// File: rtl/mem_addr_mux_pkg.sv
package mem_addr_mux_pkg;

  localparam int SHIFT_W = 6;

  typedef enum logic [1:0] {
    SRC_PASS = 2'b00,
    SRC_MUX  = 2'b01,
    SRC_REG  = 2'b10,
    SRC_ALT  = 2'b11
  } srcSel_e;

  // strobes from control to datapath for the current pattern word
  typedef struct packed {
    logic               useMux;
    logic               useReg;
    logic [SHIFT_W-1:0] shiftAmt;
    logic [1:0]         offCnt;
    logic               illegalHit;
    logic               readEn;
    logic               earlyCap;
  } strobe_t;

endpackage

// File: rtl/mem_addr_mux_ctrl.sv
module mem_addr_mux_ctrl
  import mem_addr_mux_pkg::*;
#(
  parameter int BASE_SHIFT = 8
) (
  input  logic       sysBusMode,
  input  logic [1:0] addrSel,
  input  logic [2:0] muxMode,
  input  logic       readCycle,
  input  logic       utaBit,
  input  logic       gpl4Dis,
  input  logic       dltBit,
  output strobe_t    strobe
);

  localparam logic [SHIFT_W-1:0] BASE = SHIFT_W'(BASE_SHIFT);

  always_comb begin
    strobe          = '0;
    strobe.shiftAmt = BASE;
    strobe.readEn   = readCycle;
    strobe.earlyCap = readCycle & utaBit & gpl4Dis & dltBit;
    case (srcSel_e'(addrSel))
      SRC_MUX: begin
        strobe.useMux = 1'b1;
        case (muxMode)
          3'b000, 3'b001, 3'b010, 3'b011:
            strobe.shiftAmt = BASE + SHIFT_W'(muxMode);
          3'b100: begin
            strobe.shiftAmt = BASE + SHIFT_W'(4);
            strobe.offCnt   = 2'd1;
          end
          3'b101: begin
            strobe.shiftAmt = BASE + SHIFT_W'(5);
            strobe.offCnt   = 2'd2;
          end
          default: begin
            strobe.shiftAmt   = BASE;
            strobe.illegalHit = 1'b1;
          end
        endcase
      end
      SRC_REG: strobe.useReg = !sysBusMode;
      default: ;
    endcase
  end

endmodule

// File: rtl/mem_addr_mux_dp.sv
module mem_addr_mux_dp
  import mem_addr_mux_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PIN_W    = 16,
  parameter int REG_KEEP = 18,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] masterAddr,
  input  logic [ADDR_W-1:0] marValue,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memAddrOe,
  output logic              illegalMode,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int HI_W = ADDR_W - PIN_W;

  logic [PIN_W-1:0]  shiftedLow;
  logic [PIN_W-1:0]  pinOn;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] nextOe;
  logic              readReg;
  logic              earlyReg;
  logic [DATA_W-1:0] halfData;

  assign shiftedLow = PIN_W'(masterAddr >> strobe.shiftAmt);

  // top pins of the multiplexed field switch off in the narrow modes
  for (genvar g = 0; g < PIN_W; g++) begin : g_pin
    assign pinOn[g] = !(strobe.useMux &&
                        (32'(g) + 32'(strobe.offCnt) >= 32'(PIN_W)));
  end

  assign nextOe = {{HI_W{1'b1}}, pinOn};

  always_comb begin
    if (strobe.useMux)
      nextAddr = {masterAddr[ADDR_W-1:PIN_W], shiftedLow & pinOn};
    else if (strobe.useReg)
      nextAddr = ADDR_W'(marValue[REG_KEEP-1:0]);
    else
      nextAddr = masterAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr     <= '0;
      memAddrOe   <= '1;
      illegalMode <= 1'b0;
      readReg     <= 1'b0;
      earlyReg    <= 1'b0;
      rdValid     <= 1'b0;
      rdData      <= '0;
    end else begin
      memAddr     <= nextAddr;
      memAddrOe   <= nextOe;
      illegalMode <= illegalMode | strobe.illegalHit;
      readReg     <= strobe.readEn;
      earlyReg    <= strobe.earlyCap;
      rdValid     <= readReg;
      if (readReg)
        rdData <= earlyReg ? halfData : dataIn;
    end
  end

  // half-cycle-early latch, armed by the registered capture control
  always_ff @(negedge clk) begin
    if (!rstN)
      halfData <= '0;
    else if (earlyReg)
      halfData <= dataIn;
  end

endmodule

// File: rtl/mem_addr_mux.sv
module mem_addr_mux
  import mem_addr_mux_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PIN_W      = 16,
  parameter int REG_KEEP   = 18,
  parameter int DATA_W     = 32,
  parameter int BASE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysBusMode,
  input  logic [1:0]        addrSel,
  input  logic [2:0]        muxMode,
  input  logic [ADDR_W-1:0] masterAddr,
  input  logic [ADDR_W-1:0] marValue,
  input  logic              readCycle,
  input  logic              utaBit,
  input  logic              gpl4Dis,
  input  logic              dltBit,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memAddrOe,
  output logic              illegalMode,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  strobe_t strobe;

  mem_addr_mux_ctrl #(.BASE_SHIFT(BASE_SHIFT)) ctrl_i (
    .sysBusMode(sysBusMode),
    .addrSel   (addrSel),
    .muxMode   (muxMode),
    .readCycle (readCycle),
    .utaBit    (utaBit),
    .gpl4Dis   (gpl4Dis),
    .dltBit    (dltBit),
    .strobe    (strobe)
  );

  mem_addr_mux_dp #(
    .ADDR_W(ADDR_W), .PIN_W(PIN_W), .REG_KEEP(REG_KEEP), .DATA_W(DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .masterAddr (masterAddr),
    .marValue   (marValue),
    .dataIn     (dataIn),
    .memAddr    (memAddr),
    .memAddrOe  (memAddrOe),
    .illegalMode(illegalMode),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

endmodule

// File: rtl/mem_addr_mux_chk.sv
module mem_addr_mux_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sysBusMode,
  input logic [1:0]  addrSel,
  input logic [2:0]  muxMode,
  input logic [31:0] masterAddr,
  input logic [31:0] marValue,
  input logic        readCycle,
  input logic        utaBit,
  input logic        gpl4Dis,
  input logic        dltBit,
  input logic [31:0] dataIn,
  input logic [31:0] memAddr,
  input logic [31:0] memAddrOe,
  input logic        illegalMode,
  input logic [31:0] rdData,
  input logic        rdValid
);

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b00) |=> (memAddr == $past(masterAddr)) && (&memAddrOe));

  a_r3_two_pins_off: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b01 && muxMode == 3'b101) |=>
      (memAddrOe[15:14] == 2'b00) && (memAddr[15:14] == 2'b00));

  a_r4_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b01 && muxMode[2:1] == 2'b11) |=> illegalMode);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |=> illegalMode);

  a_r5_reg_local: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b10 && !sysBusMode) |=>
      memAddr == {14'd0, $past(marValue[17:0])});

  a_r6_reg_refused: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b10 && sysBusMode) |=> memAddr == $past(masterAddr));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    readCycle |-> ##2 rdValid);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !readCycle |-> ##2 ($stable(rdData) && !rdValid));

  wire unusedChk = ^{utaBit, gpl4Dis, dltBit, dataIn};

endmodule

bind mem_addr_mux mem_addr_mux_chk chk_i (.*);

// File: tb/mem_addr_mux_tb_top.sv
`timescale 1ns/1ps
module mem_addr_mux_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysBusMode = 1'b0;
  logic [1:0]  addrSel = 2'b00;
  logic [2:0]  muxMode = 3'b000;
  logic [31:0] masterAddr = '0;
  logic [31:0] marValue = '0;
  logic        readCycle = 1'b0;
  logic        utaBit = 1'b0;
  logic        gpl4Dis = 1'b0;
  logic        dltBit = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] memAddr, memAddrOe, rdData;
  logic        illegalMode, rdValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  mem_addr_mux dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expMux(input logic [31:0] a, input logic [2:0] m);
    int sh;
    logic [15:0] low;
    case (m)
      3'd1: sh = 9;
      3'd2: sh = 10;
      3'd3: sh = 11;
      3'd4: sh = 12;
      3'd5: sh = 13;
      default: sh = 8;
    endcase
    low = 16'(a >> sh);
    if (m == 3'd4) low[15] = 1'b0;
    if (m == 3'd5) low[15:14] = 2'b00;
    return {a[31:16], low};
  endfunction

  function automatic logic [31:0] expOe(input logic [2:0] m);
    if (m == 3'd4) return 32'hFFFF_7FFF;
    if (m == 3'd5) return 32'hFFFF_3FFF;
    return 32'hFFFF_FFFF;
  endfunction

  // present one address word at a falling edge, look after the rising edge
  task automatic drive(input logic [1:0] sel, input logic [2:0] mode,
                       input logic sysBus, input logic [31:0] ma, input logic [31:0] mr);
    addrSel = sel; muxMode = mode; sysBusMode = sysBus;
    masterAddr = ma; marValue = mr;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 addr", memAddr, 32'h0);
    check("R9 oe", memAddrOe, 32'hFFFF_FFFF);
    check("R9 flag", {31'd0, illegalMode}, 32'd0);
    check("R9 data", rdData, 32'h0);
    check("R9 valid", {31'd0, rdValid}, 32'd0);
  endtask

  task automatic testPass();
    drive(2'b00, 3'd5, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678);
    check("R1 pass 00", memAddr, 32'hDEAD_BEEF);
    check("R1 oe", memAddrOe, 32'hFFFF_FFFF);
    drive(2'b11, 3'd0, 1'b0, 32'h0F1E_2D3C, 32'h0);
    check("R1 pass 11", memAddr, 32'h0F1E_2D3C);
  endtask

  task automatic testMuxWide();
    for (int m = 0; m < 4; m++) begin
      drive(2'b01, 3'(m), 1'b0, 32'hA5C3_96F1, 32'h0);
      check($sformatf("R2 mode %0d", m), memAddr, expMux(32'hA5C3_96F1, 3'(m)));
      check("R2 oe", memAddrOe, 32'hFFFF_FFFF);
    end
  endtask

  task automatic testMuxNarrow();
    for (int m = 4; m < 6; m++) begin
      drive(2'b01, 3'(m), 1'b0, 32'hFFFF_FFFF, 32'h0);
      check($sformatf("R3 mode %0d addr", m), memAddr, expMux(32'hFFFF_FFFF, 3'(m)));
      check($sformatf("R3 mode %0d oe", m), memAddrOe, expOe(3'(m)));
    end
    check("R4 flag clear on legal modes", {31'd0, illegalMode}, 32'd0);
  endtask

  task automatic testReg();
    drive(2'b10, 3'd0, 1'b0, 32'h1111_2222, 32'hFFFF_FFFF);
    check("R5 reg local", memAddr, 32'h0003_FFFF);
    drive(2'b10, 3'd0, 1'b0, 32'h1111_2222, 32'hABCD_1234);
    check("R5 reg local 2", memAddr, 32'h0001_1234);
    drive(2'b10, 3'd0, 1'b1, 32'h1111_2222, 32'hABCD_1234);
    check("R6 reg refused", memAddr, 32'h1111_2222);
  endtask

  task automatic testReserved();
    drive(2'b01, 3'd6, 1'b0, 32'h7654_3210, 32'h0);
    check("R4 mode 6 value", memAddr, expMux(32'h7654_3210, 3'd0));
    check("R4 flag set", {31'd0, illegalMode}, 32'd1);
    drive(2'b00, 3'd0, 1'b0, 32'h0, 32'h0);
    drive(2'b01, 3'd1, 1'b0, 32'h0, 32'h0);
    check("R4 flag sticky", {31'd0, illegalMode}, 32'd1);
    drive(2'b01, 3'd7, 1'b0, 32'h8000_FF00, 32'h0);
    check("R4 mode 7 value", memAddr, expMux(32'h8000_FF00, 3'd0));
  endtask

  // read word at edge k, data changes just after the falling edge, look after k+1
  task automatic testCapture(input string req, input logic uta, input logic gdis,
                             input logic dlt, input logic early, input logic [31:0] first,
                             input logic [31:0] second);
    logic [31:0] want;
    readCycle = 1'b1; utaBit = uta; gpl4Dis = gdis; dltBit = dlt; dataIn = first;
    @(posedge clk);
    @(negedge clk);
    readCycle = 1'b0; utaBit = 1'b0; gpl4Dis = 1'b0; dltBit = 1'b0;
    #1 dataIn = second;
    @(negedge clk);
    want = early ? first : second;
    check(req, rdData, want);
    check("R10 valid pulse", {31'd0, rdValid}, 32'd1);
    dataIn = 32'hCAFE_0000;
    @(negedge clk);
    check("R10 valid drops", {31'd0, rdValid}, 32'd0);
    check("R10 data holds", rdData, want);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPass();
    testMuxWide();
    testMuxNarrow();
    testReg();
    testReserved();
    testCapture("R7 early capture", 1'b1, 1'b1, 1'b1, 1'b1, 32'h1111_AAAA, 32'h2222_BBBB);
    testCapture("R8 dlt clear", 1'b1, 1'b1, 1'b0, 1'b0, 32'h3333_CCCC, 32'h4444_DDDD);
    testCapture("R8 line not disabled", 1'b1, 1'b0, 1'b1, 1'b0, 32'h5555_EEEE, 32'h6666_FFFF);
    testCapture("R8 no ack bit", 1'b0, 1'b1, 1'b1, 1'b0, 32'h7777_0101, 32'h8888_0202);
    testCapture("R7 early again", 1'b1, 1'b1, 1'b1, 1'b1, 32'h9999_0303, 32'hAAAA_0404);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule